// File: doc/BRIEF.md
# Host Bus Receive-FIFO Halfword Read Port

This block is a slave port on an asynchronous 16-bit host bus. Its job is to drain a 32-bit-wide receive FIFO. The host drives active-low chip-select and read strobes, address lines A[9:1], a FIFO-select line and an endian-select line. The core samples all of these in its own clock domain. The two strobes pass through a two-flop synchronizer. A read cycle is recognised when both strobes are low, and it closes when either strobe rises.

When FIFO-select is high at cycle start, the read is served from the FIFO whatever A[9:3] hold. A host that increments its address on every access can therefore still drain the FIFO. A[1] picks which 16-bit half of the current word goes onto the bus. The endian-select line swaps the two halves first. The first FIFO read of a pair latches the word. The FIFO is popped only once the second read of the pair has ended. A FIFO read while the FIFO is empty returns zero and sets a sticky underrun flag. When FIFO-select is low, the read returns a fixed pattern.

Top module: `hostpio_rxport`

## Requirements
- R1: A read cycle starts only when both synchronized strobes are low. With both strobes going low between two clock edges, output enable is still low after the third rising edge that follows and is high after the fourth.
- R2: A cycle ends as soon as either strobe rises, in either order. Output enable is still high after the second rising edge that follows the rise and is low after the third.
- R3: After a cycle, no new cycle starts until at least one strobe has risen. Holding both strobes low for a long time counts as one read.
- R4: With FIFO-select high at cycle start, the data comes from the FIFO for any value of A[9:3].
- R5: A[1]=0 returns bits [15:0] of the word as presented, and A[1]=1 returns bits [31:16].
- R6: With endian-select high at cycle start, the word is presented as {bits[15:0], bits[31:16]} before A[1] chooses a half.
- R7: The first FIFO read of a pair latches the FIFO head word. The second FIFO read uses the latched word. One pop pulse, one clock long, follows the end of the second read, and no pop follows the first.
- R8: With FIFO-select low, a read returns 16'h5A5A. Such a read neither pops the FIFO nor disturbs an open halfword pair.
- R9: A first FIFO read while the FIFO is empty returns 16'h0000, pops nothing, and sets the underrun flag. The flag stays set until reset.
- R10: Out of reset, and whenever output enable is low, the data output is 16'h0000, and the pop and underrun outputs are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| rd_n | input | 1 | Host read strobe, active low, asynchronous |
| addr | input | 9 | Host address A[9:1]; bit 0 is A[1] |
| fifo_sel | input | 1 | High: read is a direct FIFO access |
| end_sel | input | 1 | High: swap halfwords of the FIFO word |
| rxf_data | input | 32 | FIFO head word |
| rxf_empty | input | 1 | FIFO has no word |
| rxf_pop | output | 1 | One-cycle pop request |
| hd_out | output | 16 | Read data for the host bus |
| hd_oe | output | 1 | Data bus output enable |
| underrun | output | 1 | Sticky empty-FIFO read flag |

## Verification
A wrong pairing state shows up in two ways at the ports. A pop pulse arrives after a first read or fails to arrive after a second one, within three clocks of the strobe rise. The next read then returns a half of the wrong word. A strobe-tracking fault shows as output enable rising or falling one clock early or late against the edge counts in R1 and R2. It can also show as extra pops when the strobes are held low. Swap or select faults corrupt the very read in which they occur.

// File: rtl/hpr_pkg.sv
package hpr_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;

  // Present the word, optionally with its halves exchanged.
  function automatic logic [WORD_W-1:0] hpr_order(input logic [WORD_W-1:0] w,
                                                  input logic swap);
    return swap ? {w[HALF_W-1:0], w[WORD_W-1:HALF_W]} : w;
  endfunction

  // Choose one half of the presented word.
  function automatic logic [HALF_W-1:0] hpr_pick(input logic [WORD_W-1:0] w,
                                                 input logic hi,
                                                 input logic swap);
    logic [WORD_W-1:0] o;
    o = hpr_order(w, swap);
    return hi ? o[WORD_W-1:HALF_W] : o[HALF_W-1:0];
  endfunction
endpackage

// File: rtl/hpr_sync.sv
module hpr_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) st[i] <= RST_VAL;
          else        st[i] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) st[i] <= RST_VAL;
          else        st[i] <= st[i-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/hpr_cycle_det.sv
module hpr_cycle_det (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s,
  input  logic rd_s,
  output logic start_ev,
  output logic end_ev,
  output logic in_cyc,
  output logic oe
);
  logic active;
  logic in_cyc_q, arm_q, oe_q;

  assign active   = ~cs_s & ~rd_s;
  assign start_ev = active & ~in_cyc_q;
  assign end_ev   = in_cyc_q & ~active;
  assign in_cyc   = in_cyc_q;
  assign oe       = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cyc_q <= 1'b0;
      arm_q    <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      in_cyc_q <= active;
      arm_q    <= start_ev;
      oe_q     <= active & (oe_q | arm_q);
    end
  end
endmodule

// File: rtl/hpr_word_path.sv
module hpr_word_path
  import hpr_pkg::*;
#(
  parameter int AW = 9,
  parameter logic [HALF_W-1:0] REG_PATTERN = 16'h5A5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ev,
  input  logic              end_ev,
  input  logic [AW-1:0]     addr,
  input  logic              fsel,
  input  logic              esel,
  input  logic [WORD_W-1:0] fifo_data,
  input  logic              fifo_empty,
  output logic [HALF_W-1:0] half,
  output logic              pop,
  output logic              underrun
);
  logic [WORD_W-1:0] word_q;
  logic              held_q, pend_q, pop_q, und_q;
  logic [HALF_W-1:0] half_q;
  logic              a1;

  assign a1       = addr[0];
  assign half     = half_q;
  assign pop      = pop_q;
  assign underrun = und_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      held_q <= 1'b0;
      pend_q <= 1'b0;
      pop_q  <= 1'b0;
      und_q  <= 1'b0;
      half_q <= '0;
    end else begin
      pop_q <= 1'b0;
      if (start_ev) begin
        pend_q <= 1'b0;
        if (!fsel) begin
          half_q <= REG_PATTERN;
        end else if (held_q) begin
          half_q <= hpr_pick(word_q, a1, esel);
          pend_q <= 1'b1;
        end else if (fifo_empty) begin
          half_q <= '0;
          und_q  <= 1'b1;
        end else begin
          word_q <= fifo_data;
          held_q <= 1'b1;
          half_q <= hpr_pick(fifo_data, a1, esel);
        end
      end else if (end_ev && pend_q) begin
        pop_q  <= 1'b1;
        held_q <= 1'b0;
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hostpio_rxport.sv
module hostpio_rxport
  import hpr_pkg::*;
#(
  parameter int AW = 9,
  parameter int SYNC_STAGES = 2,
  parameter logic [HALF_W-1:0] REG_PATTERN = 16'h5A5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic [AW-1:0]     addr,
  input  logic              fifo_sel,
  input  logic              end_sel,
  input  logic [WORD_W-1:0] rxf_data,
  input  logic              rxf_empty,
  output logic              rxf_pop,
  output logic [HALF_W-1:0] hd_out,
  output logic              hd_oe,
  output logic              underrun
);
  logic [1:0]        strb_s;
  logic              start_ev, end_ev, in_cyc, oe;
  logic [HALF_W-1:0] half;

  hpr_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, rd_n}), .q(strb_s)
  );

  hpr_cycle_det u_det (
    .clk(clk), .rst_n(rst_n), .cs_s(strb_s[1]), .rd_s(strb_s[0]),
    .start_ev(start_ev), .end_ev(end_ev), .in_cyc(in_cyc), .oe(oe)
  );

  hpr_word_path #(.AW(AW), .REG_PATTERN(REG_PATTERN)) u_path (
    .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .end_ev(end_ev),
    .addr(addr), .fsel(fifo_sel), .esel(end_sel),
    .fifo_data(rxf_data), .fifo_empty(rxf_empty),
    .half(half), .pop(rxf_pop), .underrun(underrun)
  );

  assign hd_oe  = oe;
  assign hd_out = oe ? half : '0;
endmodule

// File: rtl/hostpio_rxport_chk.sv
module hostpio_rxport_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_ev,
  input logic        end_ev,
  input logic        in_cyc,
  input logic        hd_oe,
  input logic [15:0] hd_out,
  input logic        rxf_pop,
  input logic        rxf_empty,
  input logic        underrun
);
  p_oe_in_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hd_oe |-> in_cyc);
  p_bus_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hd_oe |-> hd_out == 16'h0000);
  p_oe_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    end_ev |=> !hd_oe);
  p_start_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !start_ev);
  p_pop_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_pop |=> !rxf_pop);
  p_pop_after_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_pop |-> $past(end_ev));
  p_no_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_pop |-> !rxf_empty);
  p_underrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);
endmodule

bind hostpio_rxport hostpio_rxport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .end_ev(end_ev),
  .in_cyc(in_cyc), .hd_oe(hd_oe), .hd_out(hd_out), .rxf_pop(rxf_pop),
  .rxf_empty(rxf_empty), .underrun(underrun)
);

// File: tb/sim_hostpio_rxport.sv
`timescale 1ns/1ps
module sim_hostpio_rxport;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, fifo_sel = 1'b0, end_sel = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] rxf_data;
  logic        rxf_empty, rxf_pop, hd_oe, underrun;
  logic [15:0] hd_out;

  int tests = 0, fails = 0, pops = 0, fidx = 0, fcnt = 4;
  bit done = 0;
  logic [31:0] fmem [8];

  always #2.5 clk = ~clk;

  assign rxf_empty = (fidx >= fcnt);
  assign rxf_data  = rxf_empty ? 32'h0 : fmem[fidx];
  always @(posedge clk) if (rxf_pop) fidx <= fidx + 1;
  always @(negedge clk) if (rxf_pop) pops++;

  hostpio_rxport u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .addr(addr),
    .fifo_sel(fifo_sel), .end_sel(end_sel), .rxf_data(rxf_data),
    .rxf_empty(rxf_empty), .rxf_pop(rxf_pop), .hd_out(hd_out),
    .hd_oe(hd_oe), .underrun(underrun)
  );

  // {a1, fifo_sel, end_sel, A[9:3], expected half, expected pops}
  localparam logic [26:0] VEC [10] = '{
    {1'b0, 1'b1, 1'b0, 7'h00, 16'hC3D4, 1'b0},
    {1'b1, 1'b1, 1'b0, 7'h55, 16'hA1B2, 1'b1},
    {1'b0, 1'b1, 1'b1, 7'h7F, 16'h0F1E, 1'b0},
    {1'b1, 1'b1, 1'b1, 7'h2A, 16'h2D3C, 1'b1},
    {1'b0, 1'b0, 1'b0, 7'h11, 16'h5A5A, 1'b0},
    {1'b1, 1'b1, 1'b0, 7'h03, 16'h5566, 1'b0},
    {1'b1, 1'b0, 1'b1, 7'h40, 16'h5A5A, 1'b0},
    {1'b0, 1'b1, 1'b0, 7'h7E, 16'h7788, 1'b1},
    {1'b0, 1'b1, 1'b1, 7'h01, 16'h99AA, 1'b0},
    {1'b1, 1'b1, 1'b0, 7'h10, 16'h99AA, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_read(input logic a1, input logic fs, input logic es,
                         input logic [6:0] ahi, input logic [15:0] exp_d,
                         input int exp_pop, input string tag);
    int p0;
    p0 = pops;
    @(negedge clk);
    addr = {ahi, 1'b0, a1}; fifo_sel = fs; end_sel = es;
    cs_n = 1'b0; rd_n = 1'b0;
    edges(3); chk("R1 oe low after 3 edges", hd_oe, 0);
    edges(1); chk("R1 oe high after 4 edges", hd_oe, 1);
    edges(2); chk(tag, hd_out, exp_d);
    cs_n = 1'b1; rd_n = 1'b1; addr = '0;
    edges(2); chk("R2 oe held 2 edges", hd_oe, 1);
    edges(1); chk("R2 oe low after 3 edges", hd_oe, 0);
    chk("R10 bus quiet", hd_out, 0);
    edges(3); chk({tag, " pop count"}, pops - p0, exp_pop);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int p0;
    fmem[0] = 32'hA1B2C3D4; fmem[1] = 32'h0F1E2D3C;
    fmem[2] = 32'h55667788; fmem[3] = 32'h99AABBCC;
    fmem[4] = 32'hCAFEF00D; fmem[5] = 32'h12345678;
    edges(3);
    chk("R10 reset oe", hd_oe, 0); chk("R10 reset data", hd_out, 0);
    chk("R10 reset pop", rxf_pop, 0); chk("R10 reset underrun", underrun, 0);
    rst_n = 1'b1;
    edges(2);

    // R4 R5 R6 R7 R8 via the vector table
    for (int v = 0; v < 10; v++)
      do_read(VEC[v][26], VEC[v][25], VEC[v][24], VEC[v][23:17],
              VEC[v][16:1], int'(VEC[v][0]), $sformatf("R4/R5/R6/R7/R8 vec %0d", v));

    // R3: strobes held low a long time count as one read
    fcnt = 6;
    p0 = pops;
    addr = 9'h000; fifo_sel = 1'b1; end_sel = 1'b0;
    cs_n = 1'b0; rd_n = 1'b0;
    edges(40); chk("R3 long hold data", hd_out, 16'hF00D);
    cs_n = 1'b1; rd_n = 1'b1;
    edges(6); chk("R3 no pop from long hold", pops - p0, 0);

    // R2: cs first, then rd; release cs only
    addr = 9'h001; cs_n = 1'b0;
    edges(5); chk("R1 cs alone no cycle", hd_oe, 0);
    rd_n = 1'b0;
    edges(6); chk("R2 order cs-first data", hd_out, 16'hCAFE);
    cs_n = 1'b1;
    edges(3); chk("R2 cs rise ends cycle", hd_oe, 0);
    edges(3); chk("R2 pop after cs rise", pops - p0, 1);

    // R3: re-assert cs with rd still low starts a new cycle
    addr = 9'h000; cs_n = 1'b0;
    edges(6); chk("R3 new cycle after gap", hd_out, 16'h5678);
    rd_n = 1'b1;
    edges(3); chk("R2 rd rise ends cycle", hd_oe, 0);
    cs_n = 1'b1;
    edges(3); chk("R7 first read no pop", pops - p0, 1);
    do_read(1'b1, 1'b1, 1'b0, 7'h33, 16'h1234, 1, "R7 second read");

    // R9: underrun on empty FIFO, sticky through other reads
    chk("R9 flag clear before", underrun, 0);
    do_read(1'b0, 1'b1, 1'b0, 7'h05, 16'h0000, 0, "R9 empty read data");
    chk("R9 underrun set", underrun, 1);
    do_read(1'b0, 1'b0, 1'b0, 7'h05, 16'h5A5A, 0, "R8 pattern after underrun");
    chk("R9 underrun sticky", underrun, 1);
    rst_n = 1'b0;
    edges(2); chk("R10 underrun cleared by reset", underrun, 0);
    rst_n = 1'b1;
    edges(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule